// File: doc/BRIEF.md
# SPI Master Shift Engine with Chip-Select Guard Delays

This block drives one serial peripheral over the four SPI pins (serial clock, data out, data in, and an active-low select). A single 32-bit control word sets everything about a transfer: the frame length from 4 to 16 bits, the clock idle level, the capture phase, the bit order, the serial clock rate, and two guard intervals. The first guard interval runs from the moment the select line goes low to the first serial clock edge. The second runs from the last serial clock edge to the moment the select line goes high again.

Each guard interval is the product of an odd factor (1, 3, 5 or 7, chosen by a 2-bit code) and a power of two (2^(j+1), chosen by a 4-bit code j). The serial clock half period is built the same way from its own pair of codes. A transfer begins when `start` is pulsed while the engine is idle. The control word and transmit word are captured at that moment. `done` pulses once the select line has been released, and at that point the received word is valid.

Top module: `spim_guarded_master`

## Requirements
- R1: After reset, `cs_n` is 1, `sck` is 0, `busy` is 0 and `done` is 0. While idle, `sck` takes the value of control bit 26 (clock polarity) one cycle after that bit is applied.
- R2: The control word fields are: bits 30:27 frame size minus one, bit 26 clock polarity, bit 25 clock phase, bit 24 LSB-first. A frame carries size+1 bits.
- R3: The number of cycles from `cs_n` falling to the first `sck` edge equals (2p+1)·2^(j+1). Here p is control bits 23:22 and j is control bits 15:12.
- R4: The number of cycles from the last `sck` edge to `cs_n` rising equals (2p+1)·2^(j+1). Here p is control bits 21:20 and j is control bits 11:8.
- R5: Successive `sck` edges are spaced (2p+1)·2^b cycles apart, which is half of the baud divide (2p+1)·2^(b+1). Here p is control bits 17:16 and b is control bits 3:0. A frame of N bits has exactly 2N edges, so `sck` is back at the polarity level when `cs_n` rises.
- R6: `mosi` presents tx bit N-1 first when bit 24 is 0 and tx bit 0 first when bit 24 is 1, walking one position per bit. With phase 0, the first bit is on `mosi` from the cycle `cs_n` falls, and the bit changes on trailing edges. With phase 1, it changes on leading edges after the first.
- R7: `miso` is captured on leading edges with phase 0 and on trailing edges with phase 1. The bit captured for the k-th frame bit is placed at the same position `mosi` used for that bit. `rx_word` bits at and above N read 0, and the word is valid when `done` is high.
- R8: `done` is high for exactly one cycle, one cycle after `cs_n` rises. `busy` is high from the cycle `cs_n` falls until the cycle `done` rises.
- R9: A `start` pulse while `busy` is high is ignored. The control and transmit words used are those present when the transfer was accepted, and no second frame follows.
- R10: A frame size field value of 0, 1 or 2 is treated as 3, so the frame carries 4 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer when idle |
| ctrl_word | input | 32 | Transfer settings, captured at start |
| tx_word | input | 16 | Data to send, captured at start |
| miso | input | 1 | Serial data from the peripheral |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after select release |
| rx_word | output | 16 | Received data |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| cs_n | output | 1 | Active-low select |

## Verification
The bench sweeps all four odd-factor codes against several scaler codes, separately for the lead guard, the trail guard and the clock rate. It measures every edge interval in cycles, so a wrong factor table, a wrong power of two or an off-by-one in the counter each show up as a distinct count mismatch. It covers every frame size code from 0 to 15, including the three codes that must clamp to 4 bits, under all eight combinations of polarity, phase and bit order. A bench-side peripheral model captures `mosi` and returns its own word on `miso`, which separates a swapped bit order, a wrong capture edge and a wrong launch edge. A `start` pulse with a different control and data word is fired in the middle of a frame to show it has no effect.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int DATA_W  = 16;
    localparam int SCALE_W = 4;
    localparam int IDX_W   = $clog2(DATA_W);
    localparam int CNT_W   = 3 + (1 << SCALE_W) - 1 + 1;
    localparam int EDGE_W  = $clog2(2 * DATA_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_FIN
    } spim_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] lead;
        logic [CNT_W-1:0] trail;
        logic [CNT_W-1:0] half;
        logic [IDX_W:0]   nbits;
        logic             cpol;
        logic             cpha;
        logic             lsb_first;
    } spim_cfg_t;

    // odd factor (2p+1) shifted left by the scaler code plus an extra shift
    function automatic logic [CNT_W-1:0] odd_times_pow2(
        input logic [1:0]         psc,
        input logic [SCALE_W-1:0] sc,
        input int                 extra
    );
        logic [CNT_W-1:0] base;
        base = CNT_W'({psc, 1'b1});
        return base << (int'(sc) + extra);
    endfunction

endpackage

// File: rtl/spim_cfg_decode.sv
module spim_cfg_decode
    import spim_pkg::*;
(
    input  logic [31:0] ctrl_word,
    output spim_cfg_t   cfg
);

    logic [3:0] fsz_field;
    logic [3:0] fsz_eff;
    logic       unused_ctrl_bits;

    assign fsz_field        = ctrl_word[30:27];
    assign unused_ctrl_bits = ^{ctrl_word[31], ctrl_word[19:18], ctrl_word[7:4]};

    always_comb begin
        fsz_eff       = (fsz_field < 4'd3) ? 4'd3 : fsz_field;
        cfg.nbits     = {1'b0, fsz_eff} + (IDX_W+1)'(1);
        cfg.cpol      = ctrl_word[26];
        cfg.cpha      = ctrl_word[25];
        cfg.lsb_first = ctrl_word[24];
        cfg.lead      = odd_times_pow2(ctrl_word[23:22], ctrl_word[15:12], 1);
        cfg.trail     = odd_times_pow2(ctrl_word[21:20], ctrl_word[11:8], 1);
        cfg.half      = odd_times_pow2(ctrl_word[17:16], ctrl_word[3:0], 0);
    end

endmodule

// File: rtl/spim_pacer.sv
module spim_pacer #(
    parameter int CNT_W = spim_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

    // an interval never skips: a nonzero count only drops by one per cycle
    p_count_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt_q) != '0) |-> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
    parameter int DATA_W = spim_pkg::DATA_W,
    parameter int IDX_W  = spim_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] tx_in,
    input  logic [IDX_W:0]    nbits,
    input  logic              lsb_first,
    input  logic              sample_en,
    input  logic              advance_en,
    input  logic              miso,
    output logic              mosi_bit,
    output logic [DATA_W-1:0] rx_out
);

    localparam logic [IDX_W:0] ONE = (IDX_W+1)'(1);

    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic [DATA_W-1:0] rx;
        logic [IDX_W-1:0]  idx;
    } shift_regs_t;

    shift_regs_t d, q;
    logic [IDX_W:0] pos_w;

    always_comb begin
        pos_w = lsb_first ? {1'b0, q.idx} : (nbits - {1'b0, q.idx} - ONE);
    end

    always_comb begin
        d = q;
        if (load) begin
            d.tx  = tx_in;
            d.rx  = '0;
            d.idx = '0;
        end else begin
            if (sample_en) begin
                d.rx[pos_w[IDX_W-1:0]] = miso;
            end
            if (advance_en && (q.idx != IDX_W'(DATA_W - 1))) begin
                d.idx = q.idx + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign mosi_bit = q.tx[pos_w[IDX_W-1:0]];
    assign rx_out   = q.rx;

    // the bit pointer never walks past the last bit of the frame
    p_idx_in_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        advance_en |-> (({1'b0, q.idx} + ONE) < nbits));

    // capture and launch never fall on the same edge
    p_edge_split_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_en && advance_en));

endmodule

// File: rtl/spim_guarded_master.sv
module spim_guarded_master
    import spim_pkg::*;
#(
    parameter int DW = spim_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [31:0]   ctrl_word,
    input  logic [DW-1:0] tx_word,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rx_word,
    output logic          sck,
    output logic          mosi,
    output logic          cs_n
);

    typedef struct packed {
        spim_state_e       state;
        spim_cfg_t         cfg;
        logic [EDGE_W-1:0] edges;
        logic              sck;
        logic              cs_n;
        logic              done;
    } master_regs_t;

    master_regs_t d, q;

    spim_cfg_t         cfg_live;
    logic              pace_expired;
    logic              pace_load;
    logic [CNT_W-1:0]  pace_val;
    logic              sh_load;
    logic              sh_sample;
    logic              sh_advance;
    logic              sh_mosi;
    logic              toggle_now;
    logic              leading;
    logic [EDGE_W-1:0] edge_now;
    logic [EDGE_W-1:0] edge_total;

    spim_cfg_decode u_decode (
        .ctrl_word (ctrl_word),
        .cfg       (cfg_live)
    );

    spim_pacer #(.CNT_W(CNT_W)) u_pacer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pace_load),
        .load_val (pace_val),
        .expired  (pace_expired)
    );

    spim_shifter #(.DATA_W(DW), .IDX_W(IDX_W)) u_shifter (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sh_load),
        .tx_in      (tx_word),
        .nbits      (q.cfg.nbits),
        .lsb_first  (q.cfg.lsb_first),
        .sample_en  (sh_sample),
        .advance_en (sh_advance),
        .miso       (miso),
        .mosi_bit   (sh_mosi),
        .rx_out     (rx_word)
    );

    // edge bookkeeping: which serial clock edge (1..2N) fires this cycle
    always_comb begin
        edge_total = EDGE_W'({q.cfg.nbits, 1'b0});
        edge_now   = (q.state == ST_LEAD) ? EDGE_W'(1) : (q.edges + EDGE_W'(1));
        toggle_now = pace_expired && ((q.state == ST_LEAD) || (q.state == ST_SHIFT));
        leading    = edge_now[0];
        sh_sample  = toggle_now && (q.cfg.cpha ? !leading : leading);
        sh_advance = toggle_now && (q.cfg.cpha ? (leading && (edge_now != EDGE_W'(1)))
                                               : (!leading && (edge_now != edge_total)));
    end

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        pace_load = 1'b0;
        pace_val  = '0;
        sh_load   = 1'b0;
        case (q.state)
            ST_IDLE: begin
                d.sck = cfg_live.cpol;
                if (start) begin
                    d.cfg     = cfg_live;
                    d.cs_n    = 1'b0;
                    d.edges   = '0;
                    d.state   = ST_LEAD;
                    pace_load = 1'b1;
                    pace_val  = cfg_live.lead - CNT_W'(1);
                    sh_load   = 1'b1;
                end
            end
            ST_LEAD: begin
                if (toggle_now) begin
                    d.sck     = ~q.sck;
                    d.edges   = edge_now;
                    d.state   = ST_SHIFT;
                    pace_load = 1'b1;
                    pace_val  = q.cfg.half - CNT_W'(1);
                end
            end
            ST_SHIFT: begin
                if (toggle_now) begin
                    d.sck     = ~q.sck;
                    d.edges   = edge_now;
                    pace_load = 1'b1;
                    if (edge_now == edge_total) begin
                        d.state  = ST_TRAIL;
                        pace_val = q.cfg.trail - CNT_W'(1);
                    end else begin
                        pace_val = q.cfg.half - CNT_W'(1);
                    end
                end
            end
            ST_TRAIL: begin
                if (pace_expired) begin
                    d.cs_n  = 1'b1;
                    d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                d.state = ST_IDLE;
                d.done  = 1'b1;
            end
            default: begin
                d.state = ST_IDLE;
                d.cs_n  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cfg: '0, edges: '0, sck: 1'b0, cs_n: 1'b1, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy = (q.state != ST_IDLE);
    assign done = q.done;
    assign sck  = q.sck;
    assign cs_n = q.cs_n;
    assign mosi = q.cs_n ? 1'b0 : sh_mosi;

    p_select_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    p_done_after_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> done);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_clock_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (sck == q.cfg.cpol));

    p_no_clock_deselected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$stable(sck)) |-> !cs_n);

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(q.cfg));

endmodule

// File: tb/spim_guarded_master_tb.sv
module spim_guarded_master_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic [15:0] tx_word = '0;
    logic        miso = 1'b0;
    logic        busy, done, sck, mosi, cs_n;
    logic [15:0] rx_word;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // expectations for the current frame
    int   m_n, m_lead, m_trail, m_half;
    logic m_cpol, m_cpha, m_lsb;
    logic [15:0] m_slave;

    // observations
    int   t_csf, t_first, t_last, t_csr, t_done;
    int   n_edges, spacing_err, done_cnt, csf_cnt, sidx;
    logic sck_at_csr, busy_at_done, busy_low_err;
    logic [15:0] cap_tx;
    logic prev_cs, prev_sck;

    always #4 clk = ~clk;

    spim_guarded_master u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
        .tx_word(tx_word), .miso(miso), .busy(busy), .done(done),
        .rx_word(rx_word), .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int slave_pos(input int k);
        return m_lsb ? k : (m_n - 1 - k);
    endfunction

    // peripheral model and timing monitor
    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            t_csf   = cyc;
            csf_cnt = csf_cnt + 1;
            n_edges = 0;
            sidx    = 0;
            miso    = m_slave[slave_pos(0)];
        end
        if (!cs_n && !busy) busy_low_err = 1'b1;
        if (!cs_n && (sck != prev_sck)) begin
            n_edges = n_edges + 1;
            if (n_edges == 1) t_first = cyc;
            else if ((cyc - t_last) != m_half) spacing_err = spacing_err + 1;
            t_last = cyc;
            if (m_cpha ? (n_edges % 2 == 0) : (n_edges % 2 == 1))
                cap_tx[slave_pos(sidx)] = mosi;
            if (m_cpha ? ((n_edges % 2 == 1) && n_edges > 1)
                       : ((n_edges % 2 == 0) && n_edges < 2 * m_n)) begin
                sidx = sidx + 1;
                miso = m_slave[slave_pos(sidx)];
            end
        end
        if (!prev_cs && cs_n) begin
            t_csr      = cyc;
            sck_at_csr = sck;
        end
        if (done) begin
            done_cnt     = done_cnt + 1;
            t_done       = cyc;
            busy_at_done = busy;
        end
        prev_cs  = cs_n;
        prev_sck = sck;
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks = checks + 1;
        if (got != exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic run_xfer(input logic [31:0] c, input logic [15:0] tx,
                            input logic [15:0] sw, input bit bump);
        int fsz, mask;
        fsz     = int'(c[30:27]);
        m_n     = (fsz < 3) ? 4 : fsz + 1;
        m_cpol  = c[26];
        m_cpha  = c[25];
        m_lsb   = c[24];
        m_lead  = (2 * int'(c[23:22]) + 1) * (2 << c[15:12]);
        m_trail = (2 * int'(c[21:20]) + 1) * (2 << c[11:8]);
        m_half  = (2 * int'(c[17:16]) + 1) * (1 << c[3:0]);
        m_slave = sw;
        mask    = (1 << m_n) - 1;
        n_edges = 0; spacing_err = 0; done_cnt = 0; csf_cnt = 0;
        cap_tx = '0; busy_low_err = 1'b0; t_done = -1; t_csr = -1;
        ctrl_word = c;
        tx_word   = tx;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        if (bump) begin
            repeat (m_lead + 3) @(negedge clk);
            ctrl_word = c ^ 32'h0700_0000;
            tx_word   = ~tx;
            start     = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        while (done_cnt == 0) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R3", "lead cycles", t_first - t_csf, m_lead);
        chk("R4", "trail cycles", t_csr - t_last, m_trail);
        chk("R5", "edge spacing errors", spacing_err, 0);
        chk("R5", "edge count", n_edges, 2 * m_n);
        chk("R5", "sck at release", int'(sck_at_csr), int'(m_cpol));
        chk("R6", "mosi word", int'(cap_tx), int'(tx) & mask);
        chk("R7", "rx word", int'(rx_word), int'(sw) & mask);
        chk("R8", "done delay", t_done - t_csr, 1);
        chk("R8", "done pulses", done_cnt, 1);
        chk("R8", "busy at done", int'(busy_at_done), 0);
        chk("R8", "busy while selected", int'(busy_low_err), 0);
        chk("R9", "frames started", csf_cnt, 1);
    endtask

    function automatic logic [31:0] mk(input int fsz, input int pol, input int pha, input int lsb,
                                       input int lp, input int lj, input int tp, input int tj,
                                       input int bp, input int bj);
        logic [31:0] w;
        w = '0;
        w[30:27] = 4'(fsz); w[26] = 1'(pol); w[25] = 1'(pha); w[24] = 1'(lsb);
        w[23:22] = 2'(lp);  w[21:20] = 2'(tp); w[17:16] = 2'(bp);
        w[15:12] = 4'(lj);  w[11:8] = 4'(tj);  w[3:0] = 4'(bj);
        return w;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        prev_cs = 1'b1; prev_sck = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "reset cs_n", int'(cs_n), 1);
        chk("R1", "reset sck", int'(sck), 0);
        chk("R1", "reset busy", int'(busy), 0);
        chk("R1", "reset done", int'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        ctrl_word = mk(7, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        chk("R1", "idle sck follows polarity", int'(sck), 1);
        ctrl_word = '0;
        @(negedge clk);
        chk("R1", "idle sck back low", int'(sck), 0);
        // lead and trail guard sweeps
        for (int p = 0; p < 4; p++)
            for (int j = 0; j < 4; j++)
                run_xfer(mk(7, p % 2, j % 2, 0, p, j, 3 - p, 3 - j, 0, 0),
                         16'hC3A5 ^ 16'(p * 16'h1111 + j), 16'h5A3C + 16'(j * 7), 1'b0);
        // baud sweep
        for (int p = 0; p < 4; p++)
            for (int b = 0; b < 3; b++)
                run_xfer(mk(7, b % 2, p % 2, p / 2, 1, 0, 0, 1, p, b),
                         16'h00B7 + 16'(b * 16'h31), 16'h9E21 ^ 16'(p << 5), 1'b0);
        // frame size and mode sweep (R2, R10 covered through size codes 0..15)
        for (int f = 0; f < 16; f++)
            for (int m = 0; m < 8; m++)
                run_xfer(mk(f, m & 1, (m >> 1) & 1, (m >> 2) & 1, 0, 0, 0, 0, m % 2, 0),
                         16'hF00D ^ 16'(f * 16'h0913 + m), 16'h6B1E ^ 16'(m * 16'h2201 + f), 1'b0);
        // R10: explicit clamp case, all-ones data shows exactly four bits
        run_xfer(mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0), 16'hFFFF, 16'hFFFF, 1'b0);
        chk("R10", "clamped rx width", int'(rx_word), 15);
        // R9: start during a frame with different settings and data
        run_xfer(mk(9, 0, 1, 1, 1, 1, 1, 1, 1, 1), 16'h2C7B, 16'h13D9, 1'b1);
        run_xfer(mk(15, 1, 0, 0, 0, 2, 0, 2, 0, 1), 16'h8421, 16'hBEEF, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule